// File: doc/BRIEF.md
# Read-Acquire Hardware Lock Bank

This block arbitrates ownership of one shared hardware resource among several requesting functions. Each function has its own lock register in a small address window. The registers sit one stride apart from a base address. Reading a lock register is the acquire attempt. The read returns the busy state as it was before the read, and it leaves the shared busy flag set. A returned value of zero therefore means the reader now holds the lock. A returned value of one means some other function already holds it. The holder releases the lock by writing any value to its own register.

Several access ports can present requests in the same cycle. Reads that contend for a free lock are resolved in favour of the lowest function index. The block shows the lock state (busy flag and owning function index) as outputs. Retrying and timeouts are left to the requesters.

Top module: `hwsem_bank`

## Requirements
- R1: A read to a lock register returns, in bit 0 of its response, the busy state as it was before that read. All other response bits are zero. After the read the busy flag is set.
- R2: A read that returns 0 makes the reading function the owner. From the next cycle `lock_busy` is 1 and `lock_owner` shows that function's index.
- R3: A read that returns 1 does not change the busy flag or the owner. This includes a read in the same cycle as the owner's release.
- R4: A write by the owning function to its own register clears the busy flag. It also returns `lock_owner` to 0.
- R5: A write from any function other than the owner leaves the busy flag and the owner unchanged. A write while the lock is free has no effect.
- R6: When reads from several functions arrive in one cycle with the lock free, the lowest function index acquires it. The others get 1. If two ports read for the same function, the lower port number is treated as the winner.
- R7: Function f's register is at byte address `BASE_ADDR + f*STRIDE_BYTES`. An access outside the window, or not on a stride boundary, gets no response and has no effect.
- R8: After reset the busy flag is 0, `lock_owner` is 0 and no response is valid.
- R9: The data value of a release write does not matter; any value releases the lock.
- R10: A read response (`rsp_valid` high) appears exactly one cycle after the read is accepted. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | NUM_PORT | Per-port access request |
| acc_write | input | NUM_PORT | Per-port direction, 1 = write |
| acc_addr | input | NUM_PORT*ADDR_W | Per-port byte address, port p in slice p |
| acc_wdata | input | NUM_PORT*DATA_W | Per-port write data (value ignored) |
| rsp_valid | output | NUM_PORT | Per-port read response valid |
| rsp_data | output | NUM_PORT*DATA_W | Per-port read data, bit 0 = previous busy |
| lock_busy | output | 1 | Lock currently held |
| lock_owner | output | FID_W | Index of the holding function, 0 when free |

## Verification
The assertions assume that each port carries one access per cycle. They also assume the lock state changes only through hits on the decoded window, so a cycle with no valid access must leave the lock untouched. The stimulus drives at most one operation per port per cycle. It holds inputs for a whole cycle and returns all valid bits to zero between operations. Every pair of contending functions is swept on the two ports. Addresses outside the window and misaligned addresses are included on purpose, to show they leave the state untouched.

// File: rtl/hwsem_pkg.sv
package hwsem_pkg;
   localparam int FID_MAX_W = 8;

   typedef struct packed {
      logic                 hit;
      logic                 rd;
      logic                 wr;
      logic [FID_MAX_W-1:0] fid;
   } hwsem_acc_t;
endpackage

// File: rtl/hwsem_decode.sv
module hwsem_decode
   import hwsem_pkg::*;
#(
   parameter int          NUM_FUNC     = 4,
   parameter int          ADDR_W       = 12,
   parameter logic [11:0] BASE_ADDR    = 12'h100,
   parameter int          STRIDE_BYTES = 4
) (
   input  logic              valid,
   input  logic              write,
   input  logic [ADDR_W-1:0] addr,
   output hwsem_acc_t        acc
);
   localparam int               SHIFT      = $clog2(STRIDE_BYTES);
   localparam logic [ADDR_W-1:0] BASE      = ADDR_W'(BASE_ADDR);
   localparam logic [ADDR_W-1:0] SPAN      = ADDR_W'(NUM_FUNC * STRIDE_BYTES);
   localparam logic [ADDR_W-1:0] ALIGN_MSK = ADDR_W'(STRIDE_BYTES - 1);

   logic [ADDR_W-1:0] off;
   logic              in_win;

   always_comb begin
      off    = addr - BASE;
      in_win = (addr >= BASE) && (off < SPAN) && ((off & ALIGN_MSK) == '0);
      acc.hit = valid && in_win;
      acc.rd  = valid && in_win && !write;
      acc.wr  = valid && in_win && write;
      acc.fid = FID_MAX_W'(off >> SHIFT);
   end
endmodule

// File: rtl/hwsem_pick.sv
module hwsem_pick
   import hwsem_pkg::*;
#(
   parameter int NUM_PORT = 2,
   parameter int PORT_W   = 1
) (
   input  hwsem_acc_t        acc [NUM_PORT],
   output logic              win_valid,
   output logic [PORT_W-1:0] win_port,
   output logic [FID_MAX_W-1:0] win_fid
);
   always_comb begin
      win_valid = 1'b0;
      win_port  = '0;
      win_fid   = '0;
      for (int p = 0; p < NUM_PORT; p++) begin
         if (acc[p].rd && (!win_valid || acc[p].fid < win_fid)) begin
            win_valid = 1'b1;
            win_port  = PORT_W'(p);
            win_fid   = acc[p].fid;
         end
      end
   end
endmodule

// File: rtl/hwsem_bank.sv
module hwsem_bank
   import hwsem_pkg::*;
#(
   parameter int          NUM_FUNC     = 4,
   parameter int          NUM_PORT     = 2,
   parameter int          ADDR_W       = 12,
   parameter int          DATA_W       = 32,
   parameter logic [11:0] BASE_ADDR    = 12'h100,
   parameter int          STRIDE_BYTES = 4,
   localparam int         FID_W        = (NUM_FUNC > 1) ? $clog2(NUM_FUNC) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_PORT-1:0]        acc_valid,
   input  logic [NUM_PORT-1:0]        acc_write,
   input  logic [NUM_PORT*ADDR_W-1:0] acc_addr,
   input  logic [NUM_PORT*DATA_W-1:0] acc_wdata,
   output logic [NUM_PORT-1:0]        rsp_valid,
   output logic [NUM_PORT*DATA_W-1:0] rsp_data,
   output logic                       lock_busy,
   output logic [FID_W-1:0]           lock_owner
);
   localparam int PORT_W = (NUM_PORT > 1) ? $clog2(NUM_PORT) : 1;

   if (NUM_FUNC < 1 || NUM_FUNC > (1 << FID_MAX_W)) begin : g_bad_func
      $error("hwsem_bank: NUM_FUNC out of range");
   end
   if (NUM_PORT < 1) begin : g_bad_port
      $error("hwsem_bank: NUM_PORT must be at least 1");
   end
   if (STRIDE_BYTES < 1 || (STRIDE_BYTES & (STRIDE_BYTES - 1)) != 0) begin : g_bad_stride
      $error("hwsem_bank: STRIDE_BYTES must be a power of two");
   end
   if (ADDR_W > 12 || 64'(BASE_ADDR) + 64'(NUM_FUNC * STRIDE_BYTES) > (64'd1 << ADDR_W)) begin : g_bad_win
      $error("hwsem_bank: register window exceeds the address space");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("hwsem_bank: DATA_W must be positive");
   end

   hwsem_acc_t acc [NUM_PORT];

   for (genvar p = 0; p < NUM_PORT; p++) begin : g_dec
      hwsem_decode #(
         .NUM_FUNC     (NUM_FUNC),
         .ADDR_W       (ADDR_W),
         .BASE_ADDR    (BASE_ADDR),
         .STRIDE_BYTES (STRIDE_BYTES)
      ) u_dec (
         .valid (acc_valid[p]),
         .write (acc_write[p]),
         .addr  (acc_addr[p*ADDR_W +: ADDR_W]),
         .acc   (acc[p])
      );
   end

   logic                 win_valid;
   logic [PORT_W-1:0]    win_port;
   logic [FID_MAX_W-1:0] win_fid;

   hwsem_pick #(
      .NUM_PORT (NUM_PORT),
      .PORT_W   (PORT_W)
   ) u_pick (
      .acc       (acc),
      .win_valid (win_valid),
      .win_port  (win_port),
      .win_fid   (win_fid)
   );

   logic             busy_q;
   logic [FID_W-1:0] owner_q;
   logic             drop;
   logic [NUM_PORT-1:0] rsp_v_q;
   logic [NUM_PORT-1:0] rsp_b_q;

   always_comb begin
      drop = 1'b0;
      for (int p = 0; p < NUM_PORT; p++) begin
         if (acc[p].wr && busy_q && FID_W'(acc[p].fid) == owner_q) drop = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         owner_q <= '0;
         rsp_v_q <= '0;
         rsp_b_q <= '0;
      end else begin
         if (busy_q) begin
            if (drop) begin
               busy_q  <= 1'b0;
               owner_q <= '0;
            end
         end else if (win_valid) begin
            busy_q  <= 1'b1;
            owner_q <= FID_W'(win_fid);
         end
         for (int p = 0; p < NUM_PORT; p++) begin
            rsp_v_q[p] <= acc[p].rd;
            rsp_b_q[p] <= acc[p].rd &&
                          (busy_q || !(win_valid && win_port == PORT_W'(p)));
         end
      end
   end

   for (genvar p = 0; p < NUM_PORT; p++) begin : g_rsp
      if (DATA_W > 1) begin : g_wide
         assign rsp_data[p*DATA_W +: DATA_W] = {{(DATA_W-1){1'b0}}, rsp_b_q[p]};
      end else begin : g_narrow
         assign rsp_data[p*DATA_W] = rsp_b_q[p];
      end
   end

   assign rsp_valid  = rsp_v_q;
   assign lock_busy  = busy_q;
   assign lock_owner = owner_q;

   logic unused_wdata;
   assign unused_wdata = ^acc_wdata;
endmodule

// File: rtl/hwsem_bank_chk.sv
module hwsem_bank_chk #(
   parameter int NUM_PORT = 2,
   parameter int DATA_W   = 32,
   parameter int FID_W    = 2
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [NUM_PORT-1:0]        acc_valid,
   input logic [NUM_PORT-1:0]        acc_write,
   input logic [NUM_PORT-1:0]        rsp_valid,
   input logic [NUM_PORT*DATA_W-1:0] rsp_data,
   input logic                       lock_busy,
   input logic [FID_W-1:0]           lock_owner
);
   logic [NUM_PORT-1:0] granted;
   for (genvar p = 0; p < NUM_PORT; p++) begin : g_port
      assign granted[p] = rsp_valid[p] && !rsp_data[p*DATA_W];

      // R10
      rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rsp_valid[p] |-> $past(acc_valid[p] && !acc_write[p]));

      // R2
      grant_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
         granted[p] |-> lock_busy);

      // R1
      grant_from_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
         granted[p] |-> !$past(lock_busy));
   end

   // R6
   single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(granted));

   // R3
   owner_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_busy && $past(lock_busy)) |-> $stable(lock_owner));

   // R5
   idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid == '0) |=> ($stable(lock_busy) && $stable(lock_owner)));

   // R4
   free_owner_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lock_busy |-> (lock_owner == '0));
endmodule

bind hwsem_bank hwsem_bank_chk #(
   .NUM_PORT (NUM_PORT),
   .DATA_W   (DATA_W),
   .FID_W    (FID_W)
) u_hwsem_bank_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .acc_valid  (acc_valid),
   .acc_write  (acc_write),
   .rsp_valid  (rsp_valid),
   .rsp_data   (rsp_data),
   .lock_busy  (lock_busy),
   .lock_owner (lock_owner)
);

// File: tb/hwsem_bank_bench.sv
module hwsem_bank_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NF     = 4;
   localparam int NP     = 2;
   localparam int AW     = 12;
   localparam int DW     = 32;
   localparam int BASE   = 'h100;
   localparam int STRIDE = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NP-1:0]     acc_valid = '0;
   logic [NP-1:0]     acc_write = '0;
   logic [NP*AW-1:0]  acc_addr = '0;
   logic [NP*DW-1:0]  acc_wdata = '0;
   logic [NP-1:0]     rsp_valid;
   logic [NP*DW-1:0]  rsp_data;
   logic              lock_busy;
   logic [1:0]        lock_owner;

   int checks = 0;
   int failures = 0;
   bit m_busy = 0;
   int m_owner = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hwsem_bank #(
      .NUM_FUNC (NF), .NUM_PORT (NP), .ADDR_W (AW), .DATA_W (DW),
      .BASE_ADDR (12'h100), .STRIDE_BYTES (STRIDE)
   ) u_hwsem_bank (
      .clk (clk), .rst_n (rst_n),
      .acc_valid (acc_valid), .acc_write (acc_write),
      .acc_addr (acc_addr), .acc_wdata (acc_wdata),
      .rsp_valid (rsp_valid), .rsp_data (rsp_data),
      .lock_busy (lock_busy), .lock_owner (lock_owner)
   );

   task automatic check(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int fa(input int f);
      return BASE + f * STRIDE;
   endfunction

   // one cycle: drive at negedge, check results at the following negedge
   task automatic step(input bit v0, input bit w0, input int a0, input int d0,
                       input bit v1, input bit w1, input int a1, input int d1,
                       input string tag);
      bit v[NP];  bit w[NP];  int a[NP];
      bit hit[NP]; int fid[NP];
      bit e_rv[NP]; bit e_rb[NP];
      int win;
      bit rel;
      v[0] = v0; w[0] = w0; a[0] = a0;
      v[1] = v1; w[1] = w1; a[1] = a1;
      acc_valid = {v1, v0};
      acc_write = {w1, w0};
      acc_addr  = {AW'(a1), AW'(a0)};
      acc_wdata = {DW'(d1), DW'(d0)};
      win = -1;
      rel = 0;
      for (int p = 0; p < NP; p++) begin
         hit[p] = v[p] && a[p] >= BASE && a[p] < BASE + NF * STRIDE
                  && ((a[p] - BASE) % STRIDE) == 0;
         fid[p] = (a[p] - BASE) / STRIDE;
         if (hit[p] && !w[p] && (win < 0 || fid[p] < fid[win])) win = p;
         if (hit[p] && w[p] && m_busy && fid[p] == m_owner) rel = 1;
      end
      for (int p = 0; p < NP; p++) begin
         e_rv[p] = hit[p] && !w[p];
         e_rb[p] = m_busy || (win != p);
      end
      if (m_busy) begin
         if (rel) begin m_busy = 0; m_owner = 0; end
      end else if (win >= 0) begin
         m_busy = 1; m_owner = fid[win];
      end
      @(negedge clk);
      acc_valid = '0;
      for (int p = 0; p < NP; p++) begin
         check({tag, " R10 rsp_valid"}, rsp_valid[p], e_rv[p]);
         if (e_rv[p])
            check({tag, " R1 rsp_data"}, rsp_data[p*DW +: DW], DW'(e_rb[p]));
      end
      check({tag, " lock_busy"}, lock_busy, m_busy);
      check({tag, " lock_owner"}, lock_owner, m_owner);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R8 reset state
      check("R8 busy", lock_busy, 0);
      check("R8 owner", lock_owner, 0);
      check("R8 rsp_valid", rsp_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R5 write while free has no effect
      step(1, 1, fa(2), 32'h5, 0, 0, 0, 0, "R5 free-write");

      for (int x = 0; x < NF; x++) begin
         for (int y = 0; y < NF; y++) begin
            int own;
            own = (x <= y) ? x : y;
            // R6 R2 contention on a free lock
            step(1, 0, fa(x), 0, 1, 0, fa(y), 0, "R6 R2 contend");
            // R5 non-owner writes ignored
            for (int f = 0; f < NF; f++)
               if (f != own) step(1, 1, fa(f), 32'hFFFF_FFFF, 0, 0, 0, 0, "R5 non-owner");
            // R3 owner and others read while held
            step(0, 0, 0, 0, 1, 0, fa((own + 1) % NF), 0, "R3 held-read");
            // R4 R9 owner release with varying data, other reads same cycle
            step(1, 0, fa((own + 3) % NF), 0, 1, 1, fa(own), x * 16 + y, "R4 R9 R3 release");
         end
      end

      // R7 window decode
      step(1, 0, BASE - STRIDE, 0, 1, 0, BASE + NF * STRIDE, 0, "R7 outside");
      step(1, 0, BASE + 2, 0, 1, 0, BASE + STRIDE + 1, 0, "R7 misaligned");
      step(1, 0, fa(NF - 1), 0, 0, 0, 0, 0, "R7 top fid");
      step(1, 1, BASE + NF * STRIDE + 4 * (NF - 1), 0, 0, 0, 0, 0, "R7 alias write");
      step(0, 0, 0, 0, 1, 1, fa(NF - 1), 0, "R4 release top");
      // R6 same function on both ports: lower port wins
      step(1, 0, fa(1), 0, 1, 0, fa(1), 0, "R6 same fid");
      step(0, 0, 0, 0, 1, 1, fa(1), 7, "R4 release");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule